// File: doc/BRIEF.md
# Watchdog Countdown Timer with Early-Warning Interrupt

This block is a hardware watchdog that software reaches through a small byte-addressed register port. Software writes a 16-bit tick count and sets a run bit. The count then falls by one every prescaled tick. Every rewrite of the count, known as a keep-alive, restarts the countdown from the new value. If software stops rewriting the count, the counter reaches zero and the block can issue a one-cycle system reset pulse.

An optional early-warning stage sets a status flag and raises a non-maskable interrupt request at a fixed number of ticks before expiry. This gives software a last chance to log state before the reset. Expiry sets a second status flag. Both flags can be read, and software clears them by writing ones to them or by reloading the count. The remaining tick count can be read back live at any time.

The tick length is set by a clock divider parameter: the number of input clock cycles per tick, nominally 128 ms of wall time. The early-warning distance is a parameter in ticks, nominally 70 ticks, which is about 9 seconds. Timeouts at or below that distance never raise the early warning.

Top module: `wdt_timer`

## Requirements
- R1: After reset the count, the control byte and the status byte read as zero, and nmi_o and wdt_rst_o are low.
- R2: A write to offset 0x70 loads the count and restarts the tick divider. Reading offset 0x70 returns the live remaining count. While control bit 0 (run) is set, the count drops by exactly one every DIV clock cycles, and the first step comes DIV cycles after the load.
- R3: While control bit 0 is clear, the count does not change.
- R4: The count stops at zero and never wraps around. A loaded value of zero raises no event.
- R5: When the count steps from 1 to 0 with control bit 7 (reset enable) set, wdt_rst_o is high for exactly one cycle, starting at the clock edge where the count becomes zero. With bit 7 clear, wdt_rst_o stays low.
- R6: With control bit 2 (early warning) set, status bit 1 is set at the edge where the count steps down to PRE_TICKS. It is never set when bit 2 is clear or when the loaded count is at most PRE_TICKS.
- R7: Status bit 2 is set at the edge where the count steps from 1 to 0 while running.
- R8: The status byte at offset 0x6E has bits 1 and 2 only, and all other bits read as zero. Writing a 1 to either bit clears it, and writing 0 leaves it unchanged. A count load clears both bits.
- R9: nmi_o is high exactly while status bit 1 or status bit 2 is set.
- R10: The control byte at offset 0x72 reads back all eight written bits. A read-modify-write that clears only bit 0 stops the countdown and keeps the other bits.
- R11: A read at any offset other than 0x6E, 0x70 or 0x72 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Register write strobe, one cycle per write |
| addr_i | input | 8 | Byte offset of the register access |
| wdata_i | input | 16 | Write data; the byte registers use bits 7:0 |
| rdata_o | output | 16 | Read data for addr_i, combinational |
| nmi_o | output | 1 | Non-maskable interrupt request |
| wdt_rst_o | output | 1 | One-cycle reset pulse on expiry |

## Verification
The bench sweeps every loaded count from 0 to 7 against six control bytes. The control bytes cover every combination of the run, early-warning and reset-enable bits that matters. For each pair, the count, the reset pulse and the interrupt are checked on every cycle against arithmetic expectations. Counts at or below the early-warning distance separate the "warning never fires" case from a warning that fires too early or from a wrapped comparison. Runs with the run bit clear separate a held count from a drifting one. Directed sequences then cover the write-one-to-clear rules, a mid-countdown reload that must restart the divider, the read-modify-write stop, and reads at unmapped offsets.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [7:0] OFS_STAT = 8'h6E;
  localparam logic [7:0] OFS_CNT  = 8'h70;
  localparam logic [7:0] OFS_CTRL = 8'h72;

  // control bits
  localparam int C_RUN = 0;
  localparam int C_PRE = 2;
  localparam int C_RST = 7;

  // status bits
  localparam int S_PRE = 1;
  localparam int S_EXP = 2;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned DIV = 32_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  output logic tick_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] div_q;

  assign tick_o = run_i && (div_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        div_q <= '0;
    else if (restart_i) div_q <= '0;
    else if (run_i)     div_q <= (div_q == LAST) ? '0 : div_q + 1'b1;
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CW        = 16,
  parameter int PRE_TICKS = 70
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          run_i,
  input  logic          tick_i,
  output logic [CW-1:0] cnt_o,
  output logic          pre_hit_o,
  output logic          zero_hit_o
);
  logic [CW-1:0] cnt_q;
  logic          step;

  assign step       = run_i && tick_i && !load_i && (cnt_q != '0);
  // events mark the transition, not the level
  assign pre_hit_o  = step && (cnt_q == CW'(PRE_TICKS + 1));
  assign zero_hit_o = step && (cnt_q == CW'(1));
  assign cnt_o      = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (step)   cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [7:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          load_i,
  input  logic          pre_hit_i,
  input  logic          zero_hit_i,
  output logic [7:0]    ctrl_o,
  output logic [7:0]    stat_o,
  output logic          nmi_o
);
  logic [7:0] ctrl_q;
  logic       pre_q, exp_q, pre_d, exp_d;
  logic       wr_ctrl, wr_stat;

  assign wr_ctrl = we_i && (addr_i == OFS_CTRL);
  assign wr_stat = we_i && (addr_i == OFS_STAT);

  always_comb begin
    pre_d = pre_q;
    exp_d = exp_q;
    if (load_i) begin
      pre_d = 1'b0;
      exp_d = 1'b0;
    end else if (wr_stat) begin
      if (wdata_i[S_PRE]) pre_d = 1'b0;
      if (wdata_i[S_EXP]) exp_d = 1'b0;
    end
    // a new event wins over a same-cycle clear
    if (pre_hit_i && ctrl_q[C_PRE]) pre_d = 1'b1;
    if (zero_hit_i)                 exp_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      pre_q  <= 1'b0;
      exp_q  <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata_i[7:0];
      pre_q <= pre_d;
      exp_q <= exp_d;
    end
  end

  always_comb begin
    stat_o        = '0;
    stat_o[S_PRE] = pre_q;
    stat_o[S_EXP] = exp_q;
  end

  assign ctrl_o = ctrl_q;
  assign nmi_o  = pre_q | exp_q;
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
#(
  parameter int          CW        = 16,
  parameter int unsigned DIV       = 32_000_000,
  parameter int          PRE_TICKS = 70
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [7:0]  addr_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] rdata_o,
  output logic        nmi_o,
  output logic        wdt_rst_o
);
  logic          load, tick, pre_hit, zero_hit;
  logic [CW-1:0] cnt;
  logic [7:0]    ctrl, stat;
  logic          rst_q;

  assign load = we_i && (addr_i == OFS_CNT);

  wdt_prescaler #(.DIV(DIV)) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (ctrl[C_RUN]),
    .restart_i(load),
    .tick_o   (tick)
  );

  wdt_counter #(.CW(CW), .PRE_TICKS(PRE_TICKS)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .load_val_i(wdata_i[CW-1:0]),
    .run_i     (ctrl[C_RUN]),
    .tick_i    (tick),
    .cnt_o     (cnt),
    .pre_hit_o (pre_hit),
    .zero_hit_o(zero_hit)
  );

  wdt_regs #(.DW(16)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .load_i    (load),
    .pre_hit_i (pre_hit),
    .zero_hit_i(zero_hit),
    .ctrl_o    (ctrl),
    .stat_o    (stat),
    .nmi_o     (nmi_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_q <= 1'b0;
    else         rst_q <= zero_hit && ctrl[C_RST];
  end
  assign wdt_rst_o = rst_q;

  always_comb begin
    case (addr_i)
      OFS_CNT:  rdata_o = 16'(cnt);
      OFS_CTRL: rdata_o = {8'h00, ctrl};
      OFS_STAT: rdata_o = {8'h00, stat};
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/wdt_timer_chk.sv
module wdt_timer_chk #(
  parameter int CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          load_i,
  input logic [CW-1:0] cnt_i,
  input logic [7:0]    ctrl_i,
  input logic          rst_pulse_i,
  input logic          nmi_i
);
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i[0] && !load_i) |=> $stable(cnt_i)); // R3
  AST_SINGLE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> (cnt_i == $past(cnt_i) || cnt_i == CW'($past(cnt_i) - 1'b1))); // R2
  AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == '0 && !load_i) |=> cnt_i == '0); // R4
  AST_RST_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_pulse_i |=> !rst_pulse_i); // R5
  AST_RST_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_pulse_i |-> (cnt_i == '0 && $past(ctrl_i[7]))); // R5
  AST_RELOAD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !nmi_i); // R8
endmodule

bind wdt_timer wdt_timer_chk #(.CW(CW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .load_i     (load),
  .cnt_i      (cnt),
  .ctrl_i     (ctrl),
  .rst_pulse_i(wdt_rst_o),
  .nmi_i      (nmi_o)
);

// File: tb/wdt_timer_test.sv
module wdt_timer_test;
  localparam int DIV = 4;
  localparam int PRE = 3;
  localparam logic [7:0] A_STAT = 8'h6E, A_CNT = 8'h70, A_CTRL = 8'h72;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rdata;
  logic        nmi, wdt_rst;

  int total = 0;
  int bad = 0;
  logic [15:0] v;

  always #2 clk = ~clk;

  wdt_timer #(.CW(16), .DIV(DIV), .PRE_TICKS(PRE)) uut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .nmi_o(nmi), .wdt_rst_o(wdt_rst)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic run_case(input int n, input logic [7:0] c);
    bit run, pre_en, rst_en;
    run = c[0]; pre_en = c[2]; rst_en = c[7];
    wr(A_CTRL, {8'h00, c});
    wr(A_CNT, 16'(n));
    addr = A_CNT;
    for (int m = 0; m <= 4 * n + 6; m++) begin
      int ec;
      bit ep, ee;
      #1;
      ec = run ? ((m / DIV >= n) ? 0 : n - m / DIV) : n;
      ep = run && pre_en && (n > PRE) && (m >= DIV * (n - PRE));
      ee = run && (n > 0) && (m >= DIV * n);
      check(run ? (ec == 0 ? "R4 count" : "R2 count") : "R3 held count", rdata, 16'(ec));
      check("R5 reset pulse", {15'h0, wdt_rst}, {15'h0, run && rst_en && n > 0 && m == DIV * n});
      check("R9 nmi", {15'h0, nmi}, {15'h0, ep || ee});
      @(negedge clk);
    end
    rd(A_STAT, v);
    check("R6 early-warning flag", {15'h0, v[1]}, {15'h0, run && pre_en && n > PRE});
    check("R7 expiry flag", {15'h0, v[2]}, {15'h0, run && n > 0});
  endtask

  initial begin
    logic [7:0] ctrls [6];
    ctrls = '{8'h81, 8'h85, 8'h05, 8'h01, 8'h80, 8'h84};
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(A_CNT, v);  check("R1 count", v, 16'h0);
    rd(A_CTRL, v); check("R1 ctrl", v, 16'h0);
    rd(A_STAT, v); check("R1 status", v, 16'h0);
    check("R1 nmi/rst", {14'h0, nmi, wdt_rst}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(A_CNT, v);  check("R1 count after release", v, 16'h0);
    check("R1 idle outputs", {14'h0, nmi, wdt_rst}, 16'h0);

    // sweep of count versus control mode
    foreach (ctrls[k])
      for (int n = 0; n <= 7; n++) run_case(n, ctrls[k]);

    // R10 control readback and stop by read-modify-write
    wr(A_CTRL, 16'h00A5);
    rd(A_CTRL, v); check("R10 ctrl readback", v, 16'h00A5);
    wr(A_CNT, 16'd9);
    repeat (9) @(negedge clk);
    rd(A_CNT, v); check("R2 running count", v, 16'd7);
    rd(A_CTRL, v);
    wr(A_CTRL, {8'h00, v[7:0] & 8'hFE});
    rd(A_CTRL, v); check("R10 rmw keeps other bits", v, 16'h00A4);
    rd(A_CNT, v);
    begin
      logic [15:0] held;
      held = v;
      repeat (20) @(negedge clk);
      rd(A_CNT, v); check("R3 stopped count", v, held);
    end

    // R2 keep-alive restarts the divider
    wr(A_CTRL, 16'h0001);
    wr(A_CNT, 16'd6);
    repeat (6) @(negedge clk);
    rd(A_CNT, v); check("R2 before keep-alive", v, 16'd5);
    wr(A_CNT, 16'd6);
    repeat (3) @(negedge clk);
    rd(A_CNT, v); check("R2 divider restarted", v, 16'd6);
    @(negedge clk);
    rd(A_CNT, v); check("R2 first step after reload", v, 16'd5);

    // R8 status clear rules
    wr(A_CTRL, 16'h0005);
    wr(A_CNT, 16'd5);
    repeat (4 * 5 + 2) @(negedge clk);
    rd(A_STAT, v); check("R8 both flags", v, 16'h0006);
    wr(A_STAT, 16'h0002);
    rd(A_STAT, v); check("R8 w1c bit1", v, 16'h0004);
    check("R9 nmi held by bit2", {15'h0, nmi}, 16'h1);
    wr(A_STAT, 16'h0000);
    rd(A_STAT, v); check("R8 write zero no effect", v, 16'h0004);
    wr(A_STAT, 16'h00FB);
    rd(A_STAT, v); check("R8 other ones no effect", v, 16'h0004);
    wr(A_STAT, 16'h0004);
    rd(A_STAT, v); check("R8 w1c bit2", v, 16'h0000);
    check("R9 nmi low", {15'h0, nmi}, 16'h0);
    wr(A_CNT, 16'd5);
    repeat (4 * 5 + 2) @(negedge clk);
    wr(A_CNT, 16'd40);
    rd(A_STAT, v); check("R8 reload clears", v, 16'h0000);

    // R11 unmapped offsets
    rd(8'h00, v); check("R11 offset 00", v, 16'h0);
    rd(8'h71, v); check("R11 offset 71", v, 16'h0);
    rd(8'h6F, v); check("R11 offset 6F", v, 16'h0);
    rd(8'hFF, v); check("R11 offset FF", v, 16'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    bad++;
    total++;
    $display("FAIL watchdog expired act=hang exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule